// File: doc/BRIEF.md
# Hashed Page Table Insertion Engine

This engine places one address-translation entry into a hashed page table kept in a word-wide memory. A request supplies a 24-bit segment identifier, a 32-bit virtual address, a software page-table word, a flag saying that an older copy of the entry may already be in the table, and a flag asking for the coherence attribute. From these the engine builds the two 32-bit words of the hardware entry. It then derives two candidate groups of eight slots and walks them one word at a time through a single memory port.

When an older copy may exist, the engine first asks for a TLB invalidate and looks for that copy. If it finds one, it refreshes only the low word. Otherwise it takes the first slot whose valid bit is clear, looking in the primary group and then the secondary group. When both groups are full, it overwrites a primary slot chosen by a rotating pointer. Every full slot write follows an order that never exposes a valid high word beside a stale low word. Two counters report how often searches were made and how often the primary group was full.

Top module: `hpt_insert`

## Requirements
- R1: The high word written to a slot is {valid at bit 31, segment identifier at bits 30..7, secondary flag H at bit 6, virtual address bits 27..22 at bits 5..0}. H is 1 only when the slot lies in the secondary group.
- R2: With N = HASH_BITS, the primary hash is (segment identifier[N-1:0] XOR virtual address[N+11:12]). The secondary hash is the primary hash XOR all ones. A group starts at byte address TABLE_BASE + hash*64, slot k of a group starts at group + 8k, and the low word sits at slot + 4.
- R3: A request with may_exist set raises tlbi_req for exactly one cycle with tlbi_addr equal to the virtual address, and adds one to cnt_search. A request with may_exist clear does neither.
- R4: With may_exist set, the engine compares stored high words against the new high word with valid set: first the 8 primary slots with H=0, then the 8 secondary slots with H=1. On the first equal word it writes only that slot's low word and finishes with result 1 (match).
- R5: If there is no match, or may_exist is clear, the first slot whose bit 31 is clear takes the entry, searching the primary group before the secondary group. The request finishes with result 2 (free slot).
- R6: cnt_pfull increases by one each time the free-slot search finds all 8 primary slots valid.
- R7: When both groups are full, the entry goes into primary slot ((p+1) mod 8), where p is a rotating pointer that starts at 0 after reset and is set to that slot. H is 0 in the written entry and the result is 3 (evicted).
- R8: A free-slot or evicted write is exactly three memory writes, in this order: high word with bit 31 clear, then low word, then high word with bit 31 set. A match write is a single low-word write.
- R9: The low word is {software word bits 31..12, zeros at 11..5, coherent at bit 4, zeros at 3..2, protection at 1..0}. The software word has its user bit at 3, its writable bit at 4 and its dirty bit at 5. Protection is 0 when user is clear, 2 when user, writable and dirty are all set, and 3 for any other user page.
- R10: mem_req, mem_we, mem_addr and mem_wdata hold steady until a clock edge sees mem_ready high. Only one access is outstanding at a time, and read data is taken on that edge.
- R11: After reset, done, tlbi_req and mem_req are low and both counters are zero. done rises for exactly one cycle per request, with result valid (non-zero) in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (taken when idle) |
| vsid | input | 24 | Segment identifier |
| vaddr | input | 32 | Virtual address |
| swpte | input | 32 | Software page-table word |
| may_exist | input | 1 | An older copy may be in the table |
| coherent | input | 1 | Set the coherence bit in the low word |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 1 match, 2 free slot, 3 evicted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| tlbi_req | output | 1 | TLB invalidate request pulse |
| tlbi_addr | output | 32 | Address to invalidate |
| cnt_search | output | CNT_W | Count of may_exist requests |
| cnt_pfull | output | CNT_W | Count of full primary groups seen |

## Verification
tlbi_req is due in the cycle after the edge that takes start. Each memory access completes on the edge where mem_ready is high. done rises in the cycle after the edge that accepts the last write, and the counters are already updated in that cycle. The bench stalls the memory with a pseudo-random ready pattern, so the number of cycles to done varies from request to request. For that reason it ties no check to a fixed cycle count. It samples every signal on the falling edge, keeps each accepted write in a log, and compares the queued expectation when done is seen. One falling edge later it checks that done has dropped.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int GRP_SLOTS   = 8;
    localparam int SLOT_BYTES  = 8;
    localparam int GRP_SHIFT   = 6;
    localparam int SLOT_IDX_W  = $clog2(GRP_SLOTS);
    localparam logic [31:0] VALID_BIT = 32'h8000_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WHI0,
        ST_WLO,
        ST_WHI1
    } st_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_MATCH = 2'd1,
        RES_FREE  = 2'd2,
        RES_EVICT = 2'd3
    } res_e;
endpackage

// File: rtl/hpt_fmt.sv
module hpt_fmt (
    input  logic [23:0] vsid,
    input  logic [31:0] vaddr,
    input  logic [31:0] swpte,
    input  logic        coherent,
    output logic [31:0] hi_tag,
    output logic [31:0] lo_word
);
    logic       is_user;
    logic       wr_dirty;
    logic [1:0] prot;

    always_comb begin
        is_user  = swpte[3];
        wr_dirty = swpte[4] & swpte[5];
        if (!is_user)
            prot = 2'd0;
        else if (wr_dirty)
            prot = 2'd2;
        else
            prot = 2'd3;
        hi_tag  = {1'b0, vsid, 1'b0, vaddr[27:22]};
        lo_word = {swpte[31:12], 7'b0, coherent, 2'b0, prot};
    end
endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int          HASH_BITS  = 12,
    parameter logic [31:0] TABLE_BASE = 32'h0010_0000
) (
    input  logic [23:0] vsid,
    input  logic [31:0] vaddr,
    output logic [31:0] grp_pri,
    output logic [31:0] grp_sec
);
    import hpt_pkg::*;
    localparam logic [HASH_BITS-1:0] HMASK = '1;

    logic [15:0]          pidx;
    logic [HASH_BITS-1:0] h_pri;
    logic [HASH_BITS-1:0] h_sec;

    always_comb begin
        pidx    = vaddr[27:12];
        h_pri   = vsid[HASH_BITS-1:0] ^ pidx[HASH_BITS-1:0];
        h_sec   = h_pri ^ HMASK;
        grp_pri = TABLE_BASE + (32'(h_pri) << GRP_SHIFT);
        grp_sec = TABLE_BASE + (32'(h_sec) << GRP_SHIFT);
    end
endmodule

// File: rtl/hpt_rr.sv
module hpt_rr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] slot_next
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        slot_next = ptr_q + IDX_W'(1);
        ptr_d     = adv ? slot_next : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end
endmodule

// File: rtl/hpt_insert.sv
module hpt_insert
    import hpt_pkg::*;
#(
    parameter int          HASH_BITS  = 12,
    parameter logic [31:0] TABLE_BASE = 32'h0010_0000,
    parameter int          CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [23:0]      vsid,
    input  logic [31:0]      vaddr,
    input  logic [31:0]      swpte,
    input  logic             may_exist,
    input  logic             coherent,
    output logic             done,
    output logic [1:0]       result,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ready,
    input  logic [31:0]      mem_rdata,
    output logic             tlbi_req,
    output logic [31:0]      tlbi_addr,
    output logic [CNT_W-1:0] cnt_search,
    output logic [CNT_W-1:0] cnt_pfull
);
    localparam logic [SLOT_IDX_W-1:0] LAST_IDX = SLOT_IDX_W'(GRP_SLOTS - 1);

    typedef struct packed {
        st_e                   st;
        logic                  srch;
        logic                  grp;
        logic [SLOT_IDX_W-1:0] idx;
        res_e                  res;
        logic                  done;
        logic                  tlbi;
        logic [23:0]           vsid;
        logic [31:0]           va;
        logic [31:0]           pte;
        logic                  coh;
        logic [CNT_W-1:0]      n_srch;
        logic [CNT_W-1:0]      n_pfull;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [31:0]           hi_tag, lo_word, grp_pri, grp_sec;
    logic [31:0]           slot_addr, hi_h, hi_v;
    logic                  rr_adv;
    logic [SLOT_IDX_W-1:0] rr_slot;

    hpt_fmt u_fmt (
        .vsid     (ctl_q.vsid),
        .vaddr    (ctl_q.va),
        .swpte    (ctl_q.pte),
        .coherent (ctl_q.coh),
        .hi_tag   (hi_tag),
        .lo_word  (lo_word)
    );

    hpt_hash #(
        .HASH_BITS  (HASH_BITS),
        .TABLE_BASE (TABLE_BASE)
    ) u_hash (
        .vsid    (ctl_q.vsid),
        .vaddr   (ctl_q.va),
        .grp_pri (grp_pri),
        .grp_sec (grp_sec)
    );

    hpt_rr #(
        .IDX_W (SLOT_IDX_W)
    ) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (rr_adv),
        .slot_next (rr_slot)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.tlbi = 1'b0;
        rr_adv    = 1'b0;

        hi_h      = hi_tag | {25'b0, ctl_q.grp, 6'b0};
        hi_v      = hi_h | VALID_BIT;
        slot_addr = (ctl_q.grp ? grp_sec : grp_pri)
                  + {{(32-SLOT_IDX_W-3){1'b0}}, ctl_q.idx, 3'b000};

        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = slot_addr;
        mem_wdata = '0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_SCAN;
                    ctl_d.srch = may_exist;
                    ctl_d.grp  = 1'b0;
                    ctl_d.idx  = '0;
                    ctl_d.res  = RES_NONE;
                    ctl_d.vsid = vsid;
                    ctl_d.va   = vaddr;
                    ctl_d.pte  = swpte;
                    ctl_d.coh  = coherent;
                    ctl_d.tlbi = may_exist;
                    if (may_exist)
                        ctl_d.n_srch = ctl_q.n_srch + CNT_W'(1);
                end
            end
            ST_SCAN: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    if (ctl_q.srch && (mem_rdata == hi_v)) begin
                        ctl_d.st  = ST_WLO;
                        ctl_d.res = RES_MATCH;
                    end else if (!ctl_q.srch && !mem_rdata[31]) begin
                        ctl_d.st  = ST_WHI0;
                        ctl_d.res = RES_FREE;
                    end else if (ctl_q.idx != LAST_IDX) begin
                        ctl_d.idx = ctl_q.idx + SLOT_IDX_W'(1);
                    end else if (!ctl_q.grp) begin
                        ctl_d.grp = 1'b1;
                        ctl_d.idx = '0;
                        if (!ctl_q.srch)
                            ctl_d.n_pfull = ctl_q.n_pfull + CNT_W'(1);
                    end else if (ctl_q.srch) begin
                        ctl_d.srch = 1'b0;
                        ctl_d.grp  = 1'b0;
                        ctl_d.idx  = '0;
                    end else begin
                        rr_adv    = 1'b1;
                        ctl_d.grp = 1'b0;
                        ctl_d.idx = rr_slot;
                        ctl_d.res = RES_EVICT;
                        ctl_d.st  = ST_WHI0;
                    end
                end
            end
            ST_WHI0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hi_h;
                if (mem_ready)
                    ctl_d.st = ST_WLO;
            end
            ST_WLO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_addr + 32'd4;
                mem_wdata = lo_word;
                if (mem_ready) begin
                    if (ctl_q.res == RES_MATCH) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st = ST_WHI1;
                    end
                end
            end
            ST_WHI1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hi_v;
                if (mem_ready) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, res: RES_NONE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done       = ctl_q.done;
    assign result     = ctl_q.res;
    assign tlbi_req   = ctl_q.tlbi;
    assign tlbi_addr  = ctl_q.va;
    assign cnt_search = ctl_q.n_srch;
    assign cnt_pfull  = ctl_q.n_pfull;
endmodule

// File: rtl/hpt_insert_chk.sv
module hpt_insert_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ready,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             done,
    input logic [1:0]       result,
    input logic             tlbi_req,
    input logic [CNT_W-1:0] cnt_search,
    input logic [CNT_W-1:0] cnt_pfull
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd0));

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_we && mem_ready));

    assert_pfull_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_pfull) |-> (cnt_pfull == $past(cnt_pfull) + CNT_W'(1)));

    assert_search_tlbi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_search) |-> tlbi_req);

    assert_tlbi_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tlbi_req |=> !tlbi_req);
endmodule

bind hpt_insert hpt_insert_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_hpt_insert.sv
`timescale 1ns/1ps
module sim_hpt_insert;
    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam logic [31:0] VA   = 32'h0345_6000;
    localparam logic [31:0] FULL = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] vsid = '0;
    logic [31:0] vaddr = '0;
    logic [31:0] swpte = '0;
    logic        may_exist = 1'b0;
    logic        coherent = 1'b0;
    logic        done;
    logic [1:0]  result;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tlbi_req;
    logic [31:0] tlbi_addr;
    logic [15:0] cnt_search, cnt_pfull;

    always #2.5 clk = ~clk;

    hpt_insert u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .vaddr(vaddr),
        .swpte(swpte), .may_exist(may_exist), .coherent(coherent),
        .done(done), .result(result), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .tlbi_req(tlbi_req), .tlbi_addr(tlbi_addr),
        .cnt_search(cnt_search), .cnt_pfull(cnt_pfull)
    );

    typedef struct {
        int          res;
        logic [31:0] slot;
        logic [31:0] hi;
        logic [31:0] lo;
        int          n_srch;
        int          n_pfull;
        int          n_tlbi;
    } exp_t;

    logic [31:0] mem [int unsigned];
    exp_t        q_exp[$];
    logic [31:0] wl_addr[$];
    logic [31:0] wl_data[$];
    int          checks = 0;
    int          errors = 0;
    int          tlbi_seen = 0;
    bit          done_seen = 1'b0;
    logic [7:0]  lfsr = 8'h5A;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] grp_addr(input logic [23:0] v, input bit sec);
        logic [11:0] h;
        h = v[11:0] ^ VA[23:12];
        if (sec) h = ~h;
        return BASE + ({20'b0, h} << 6);
    endfunction

    function automatic logic [31:0] exp_lo(input logic [31:0] p, input bit coh);
        logic [1:0] pr;
        if (!p[3]) pr = 2'd0;
        else if (p[4] && p[5]) pr = 2'd2;
        else pr = 2'd3;
        return {p[31:12], 7'b0, coh, 2'b0, pr};
    endfunction

    function automatic logic [31:0] exp_hi(input logic [23:0] v, input bit h);
        return {1'b1, v, h, VA[27:22]};
    endfunction

    task automatic fill(input logic [31:0] g, input int skip);
        for (int i = 0; i < 8; i++)
            if (i != skip) mem[g + 32'(i * 8)] = FULL;
    endtask

    // monitor / memory model, all on the falling edge
    always @(negedge clk) begin
        exp_t  e;
        string tg;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = mem_req && (lfsr[1:0] != 2'b00);
        if (mem_ready) begin
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wl_addr.push_back(mem_addr);
                wl_data.push_back(mem_wdata);
            end else begin
                mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            end
        end
        if (tlbi_req) begin
            tlbi_seen++;
            chk(tlbi_addr == VA, "R3", tlbi_addr, VA);
        end
        if (done) begin
            done_seen = 1'b1;
            if (q_exp.size() == 0) begin
                chk(1'b0, "R11", 32'(result), 32'h0);
            end else begin
                e  = q_exp.pop_front();
                tg = (e.res == 1) ? "R4" : (e.res == 2) ? "R5" : "R7";
                chk(32'(result) == 32'(e.res), tg, 32'(result), 32'(e.res));
                if (e.res == 1) begin
                    chk(wl_addr.size() == 1, "R8", 32'(wl_addr.size()), 32'd1);
                    if (wl_addr.size() == 1) begin
                        chk(wl_addr[0] == e.slot + 4, "R2", wl_addr[0], e.slot + 4);
                        chk(wl_data[0] == e.lo, "R9", wl_data[0], e.lo);
                    end
                end else begin
                    chk(wl_addr.size() == 3, "R8", 32'(wl_addr.size()), 32'd3);
                    if (wl_addr.size() == 3) begin
                        chk(wl_addr[0] == e.slot, "R2", wl_addr[0], e.slot);
                        chk(wl_data[0] == (e.hi & ~FULL), "R8", wl_data[0], e.hi & ~FULL);
                        chk(wl_addr[1] == e.slot + 4, "R8", wl_addr[1], e.slot + 4);
                        chk(wl_data[1] == e.lo, "R9", wl_data[1], e.lo);
                        chk(wl_addr[2] == e.slot, "R8", wl_addr[2], e.slot);
                        chk(wl_data[2] == e.hi, "R1", wl_data[2], e.hi);
                    end
                end
                chk(32'(cnt_search) == 32'(e.n_srch), "R3", 32'(cnt_search), 32'(e.n_srch));
                chk(32'(cnt_pfull) == 32'(e.n_pfull), "R6", 32'(cnt_pfull), 32'(e.n_pfull));
                chk(tlbi_seen == e.n_tlbi, "R3", 32'(tlbi_seen), 32'(e.n_tlbi));
            end
            wl_addr.delete();
            wl_data.delete();
        end
    end

    task automatic run(input logic [23:0] v, input logic [31:0] p, input bit me,
                       input bit coh, input int res, input bit sec, input int idx,
                       input int ns, input int npf, input int nt);
        exp_t e;
        int   cyc;
        e.res     = res;
        e.slot    = grp_addr(v, sec) + 32'(idx * 8);
        e.hi      = exp_hi(v, sec);
        e.lo      = exp_lo(p, coh);
        e.n_srch  = ns;
        e.n_pfull = npf;
        e.n_tlbi  = nt;
        q_exp.push_back(e);
        @(negedge clk);
        vsid = v; vaddr = VA; swpte = p; may_exist = me; coherent = coh;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done_seen && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done_seen) chk(1'b0, "R11", 32'(cyc), 32'd2000);
        done_seen = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R11", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(done == 1'b0, "R11", 32'(done), 32'd0);
        chk(mem_req == 1'b0, "R10", 32'(mem_req), 32'd0);
        chk(tlbi_req == 1'b0, "R11", 32'(tlbi_req), 32'd0);
        chk(cnt_search == 16'd0 && cnt_pfull == 16'd0, "R11",
            {cnt_search, cnt_pfull}, 32'd0);
        rst_n = 1'b1;

        // R5 R9: empty table, kernel page, primary slot 0
        run(24'h10, 32'h1234_5000, 1'b0, 1'b0, 2, 1'b0, 0, 0, 0, 0);
        // R4 R3 R9: refresh existing copy, user writable dirty, coherent
        run(24'h10, 32'h1234_6038, 1'b1, 1'b1, 1, 1'b0, 0, 1, 0, 1);
        // R5 R6 R1: primary full -> secondary slot 0 with H, user read-only
        fill(grp_addr(24'h20, 1'b0), -1);
        run(24'h20, 32'h0ABC_D008, 1'b0, 1'b0, 2, 1'b1, 0, 1, 1, 1);
        // R7: both full -> primary slot 1
        fill(grp_addr(24'h30, 1'b0), -1);
        fill(grp_addr(24'h30, 1'b1), -1);
        run(24'h30, 32'h0000_1028, 1'b0, 1'b1, 3, 1'b0, 1, 1, 2, 1);
        // R7 R3: search misses, both full -> primary slot 2
        fill(grp_addr(24'h40, 1'b0), -1);
        fill(grp_addr(24'h40, 1'b1), -1);
        run(24'h40, 32'hFFFF_F038, 1'b1, 1'b0, 3, 1'b0, 2, 2, 3, 2);
        // R4: match in secondary slot 3 (H set)
        fill(grp_addr(24'h50, 1'b0), -1);
        mem[grp_addr(24'h50, 1'b1) + 32'd24] = exp_hi(24'h50, 1'b1);
        run(24'h50, 32'h5555_5018, 1'b1, 1'b0, 1, 1'b1, 3, 3, 3, 3);
        // R5 R9: no match, primary slot 5 free, user writable not dirty
        fill(grp_addr(24'h60, 1'b0), 5);
        run(24'h60, 32'h7777_7018, 1'b1, 1'b1, 2, 1'b0, 5, 4, 3, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule